// File: doc/BRIEF.md
# NAND Flash SDR Bus Cycle Decoder

This block sits on the device side of an asynchronous single-data-rate NAND flash bus. It runs on a free-running system clock that is much faster than the bus strobes. All pin inputs pass through a two-flop synchronizer. Each low-to-high transition of the active-low write strobe, detected in the clock domain, latches one bus cycle.

The command and address latch levels sampled with that strobe classify the cycle:
- command latch high and address latch low gives a command cycle;
- address latch high and command latch low gives an address cycle;
- both low gives a data cycle;
- both high is invalid and is dropped.

Command and data cycles each raise a one-clock strobe together with the bus byte. Address cycles go into a byte assembler that splits the stream into a column field and a row field. The split depends on the last opcode seen: block erase sends row bytes only. After the last expected byte, the assembler pulses address-complete with the assembled fields, the page, block and logical-unit parts of the row, and an error flag for reserved high bits that are set.

While chip enable (active low) is high, every strobe is ignored. The block does not drive read data, check opcodes or sequence operations.

Top module: `nand_cycle_decoder`

## Requirements
- R1: A write-strobe rise with command latch high and address latch low produces `cmd_valid_o` high for exactly one clock, with `cmd_code_o` equal to the bus byte. The pulse is visible after the third rising clock edge that follows the strobe rise.
- R2: A write-strobe rise with both latch enables low produces `data_valid_o` high for exactly one clock, with `data_o` equal to the bus byte, on the same cycle timing as R1. `cmd_valid_o` and `data_valid_o` are never high together.
- R3: After any opcode other than 60h, five address bytes are expected. Bytes 1 and 2 form `col_addr_o`, with the first byte in bits 7:0. Bytes 3, 4 and 5 form `row_addr_o`, with byte 3 in bits 7:0 and byte 5 in bits 23:16. `addr_done_o` pulses for one clock only for the fifth byte, one clock later than the R1 timing.
- R4: After opcode 60h, only three row bytes are expected and `addr_done_o` pulses on the third byte. `col_addr_o` reads zero.
- R5: `page_o` is `row_addr_o[6:0]`, `block_o` is `row_addr_o[18:7]` and `lun_o` is `row_addr_o[19]`.
- R6: With `addr_done_o`, `addr_err_o` is high when column bits 15:12 or row bits 23:20 hold any one, and low otherwise. `addr_err_o` is low whenever `addr_done_o` is low.
- R7: With chip enable high, a strobe rise produces no output strobe and does not advance the address byte count.
- R8: A command cycle restarts the address byte count, so a partial address sequence is discarded.
- R9: A cycle with both latch enables high produces no output strobe and does not advance the address byte count.
- R10: After reset, `cmd_valid_o`, `data_valid_o`, `addr_done_o` and `addr_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n_i | input | 1 | Chip enable, active low, asynchronous |
| cle_i | input | 1 | Command latch enable, asynchronous |
| ale_i | input | 1 | Address latch enable, asynchronous |
| we_n_i | input | 1 | Write strobe, active low, latches on its rise |
| io_i | input | 8 | Bus byte |
| cmd_valid_o | output | 1 | One-clock command strobe |
| cmd_code_o | output | 8 | Opcode, valid with `cmd_valid_o` |
| data_valid_o | output | 1 | One-clock data strobe |
| data_o | output | 8 | Data byte, valid with `data_valid_o` |
| addr_done_o | output | 1 | One-clock address-complete strobe |
| addr_err_o | output | 1 | Reserved address bits set, valid with `addr_done_o` |
| col_addr_o | output | 16 | Assembled column address |
| row_addr_o | output | 24 | Assembled row address |
| page_o | output | 7 | Page field of the row |
| block_o | output | 12 | Block field of the row |
| lun_o | output | 1 | Logical-unit field of the row |

## Verification
The timing of each output after a strobe rise is as follows. The synchronizer adds two clocks and the edge-detect register one more, so a command or data strobe appears after the third rising clock edge following the strobe rise. The address assembler registers once more, so `addr_done_o` and its fields appear after the fourth edge.

The bench raises the strobe on a falling clock edge, counts exactly three rising edges and samples 1 ns later for the command and data strobes. It then samples once more after the next rising edge for the address results. At that second sample it also confirms that the command strobe has already fallen. Ignored cycles (chip disabled, both latches high) are checked at the same two sample points, and through the byte count of the address sequence that follows them.

// File: rtl/nand_dec_pkg.sv
package nand_dec_pkg;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_CMD  = 2'd1,
    KIND_ADDR = 2'd2,
    KIND_DATA = 2'd3
  } cyc_kind_t;
endpackage

// File: rtl/nand_sync_pipe.sv
// Multi-stage synchronizer for a bundle of asynchronous pin levels.
module nand_sync_pipe #(
  parameter int              WIDTH   = 12,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/nand_cycle_classify.sv
// Detects the write-strobe rise and classifies the latched bus cycle.
module nand_cycle_classify
  import nand_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             we_n,
  input  logic [BUS_W-1:0] io,
  output logic             cmd_stb,
  output logic             addr_stb,
  output logic             data_stb,
  output logic [BUS_W-1:0] byte_q
);
  logic      we_prev;
  logic      we_rise;
  cyc_kind_t kind;

  assign we_rise = we_n & ~we_prev;

  always_comb begin
    kind = KIND_NONE;
    if (we_rise && !ce_n) begin
      unique case ({cle, ale})
        2'b10:   kind = KIND_CMD;
        2'b01:   kind = KIND_ADDR;
        2'b00:   kind = KIND_DATA;
        default: kind = KIND_NONE;  // both latches high: invalid cycle
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      we_prev  <= 1'b1;
      cmd_stb  <= 1'b0;
      addr_stb <= 1'b0;
      data_stb <= 1'b0;
      byte_q   <= '0;
    end else begin
      we_prev  <= we_n;
      cmd_stb  <= (kind == KIND_CMD);
      addr_stb <= (kind == KIND_ADDR);
      data_stb <= (kind == KIND_DATA);
      if (kind != KIND_NONE) byte_q <= io;
    end
  end
endmodule

// File: rtl/nand_addr_gather.sv
// Assembles the address byte stream into column and row fields.
module nand_addr_gather
  import nand_dec_pkg::*;
#(
  parameter int               COL_BYTES   = 2,
  parameter int               ROW_BYTES   = 3,
  parameter int               COL_USED    = 12,
  parameter int               ROW_USED    = 20,
  parameter logic [BUS_W-1:0] ROW_ONLY_OP = 8'h60,
  localparam int COL_W = BUS_W * COL_BYTES,
  localparam int ROW_W = BUS_W * ROW_BYTES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_stb,
  input  logic             addr_stb,
  input  logic [BUS_W-1:0] byte_in,
  output logic             done_o,
  output logic             err_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int TOT   = COL_BYTES + ROW_BYTES;
  localparam int CNT_W = $clog2(TOT + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] ridx;
  logic             row_only;
  logic             is_col;
  logic             accept;
  logic             last;
  logic [COL_W-1:0] col_w, col_n;
  logic [ROW_W-1:0] row_w, row_n;
  logic             col_bad, row_bad;

  assign need   = row_only ? CNT_W'(ROW_BYTES) : CNT_W'(TOT);
  assign accept = addr_stb && (cnt < need);
  assign last   = accept && (cnt == need - CNT_W'(1));
  assign is_col = !row_only && (cnt < CNT_W'(COL_BYTES));
  assign ridx   = row_only ? cnt : cnt - CNT_W'(COL_BYTES);

  always_comb begin
    col_n = col_w;
    row_n = row_w;
    for (int k = 0; k < COL_BYTES; k++)
      if (is_col && cnt == CNT_W'(k)) col_n[BUS_W*k +: BUS_W] = byte_in;
    for (int k = 0; k < ROW_BYTES; k++)
      if (!is_col && ridx == CNT_W'(k)) row_n[BUS_W*k +: BUS_W] = byte_in;
  end

  assign col_bad = !row_only && (|(col_n >> COL_USED));
  assign row_bad = |(row_n >> ROW_USED);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      row_only <= 1'b0;
      col_w    <= '0;
      row_w    <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      col_o    <= '0;
      row_o    <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (cmd_stb) begin
        cnt      <= '0;
        row_only <= (byte_in == ROW_ONLY_OP);
        col_w    <= '0;
        row_w    <= '0;
      end else if (accept) begin
        cnt   <= cnt + CNT_W'(1);
        col_w <= col_n;
        row_w <= row_n;
        if (last) begin
          done_o <= 1'b1;
          err_o  <= col_bad || row_bad;
          col_o  <= row_only ? '0 : col_n;
          row_o  <= row_n;
        end
      end
    end
  end
endmodule

// File: rtl/nand_cycle_decoder.sv
// Device-side decoder for asynchronous single-data-rate NAND bus cycles.
module nand_cycle_decoder
  import nand_dec_pkg::*;
#(
  parameter int               COL_BYTES   = 2,
  parameter int               ROW_BYTES   = 3,
  parameter int               COL_BITS    = 12,
  parameter int               PAGE_BITS   = 7,
  parameter int               BLOCK_BITS  = 12,
  parameter int               LUN_BITS    = 1,
  parameter int               SYNC_STAGES = 2,
  parameter logic [BUS_W-1:0] ROW_ONLY_OP = 8'h60,
  localparam int COL_W = BUS_W * COL_BYTES,
  localparam int ROW_W = BUS_W * ROW_BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ce_n_i,
  input  logic                  cle_i,
  input  logic                  ale_i,
  input  logic                  we_n_i,
  input  logic [BUS_W-1:0]      io_i,
  output logic                  cmd_valid_o,
  output logic [BUS_W-1:0]      cmd_code_o,
  output logic                  data_valid_o,
  output logic [BUS_W-1:0]      data_o,
  output logic                  addr_done_o,
  output logic                  addr_err_o,
  output logic [COL_W-1:0]      col_addr_o,
  output logic [ROW_W-1:0]      row_addr_o,
  output logic [PAGE_BITS-1:0]  page_o,
  output logic [BLOCK_BITS-1:0] block_o,
  output logic [LUN_BITS-1:0]   lun_o
);
  localparam int ROW_USED = PAGE_BITS + BLOCK_BITS + LUN_BITS;
  localparam int PIN_W    = BUS_W + 4;
  localparam logic [PIN_W-1:0] PIN_RST = {1'b1, 1'b0, 1'b0, 1'b1, {BUS_W{1'b0}}};

  logic [PIN_W-1:0] pins_s;
  logic             cmd_stb, addr_stb, data_stb;
  logic [BUS_W-1:0] byte_q;

  nand_sync_pipe #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({ce_n_i, cle_i, ale_i, we_n_i, io_i}),
    .q  (pins_s)
  );

  nand_cycle_classify u_class (
    .clk     (clk),
    .rst     (rst),
    .ce_n    (pins_s[BUS_W+3]),
    .cle     (pins_s[BUS_W+2]),
    .ale     (pins_s[BUS_W+1]),
    .we_n    (pins_s[BUS_W]),
    .io      (pins_s[BUS_W-1:0]),
    .cmd_stb (cmd_stb),
    .addr_stb(addr_stb),
    .data_stb(data_stb),
    .byte_q  (byte_q)
  );

  nand_addr_gather #(
    .COL_BYTES  (COL_BYTES),
    .ROW_BYTES  (ROW_BYTES),
    .COL_USED   (COL_BITS),
    .ROW_USED   (ROW_USED),
    .ROW_ONLY_OP(ROW_ONLY_OP)
  ) u_addr (
    .clk     (clk),
    .rst     (rst),
    .cmd_stb (cmd_stb),
    .addr_stb(addr_stb),
    .byte_in (byte_q),
    .done_o  (addr_done_o),
    .err_o   (addr_err_o),
    .col_o   (col_addr_o),
    .row_o   (row_addr_o)
  );

  assign cmd_valid_o  = cmd_stb;
  assign data_valid_o = data_stb;
  assign cmd_code_o   = byte_q;
  assign data_o       = byte_q;

  // Row layout: page in the low bits, block above it, logical unit on top.
  assign page_o  = row_addr_o[PAGE_BITS-1:0];
  assign block_o = row_addr_o[PAGE_BITS +: BLOCK_BITS];
  assign lun_o   = row_addr_o[PAGE_BITS+BLOCK_BITS +: LUN_BITS];
endmodule

// File: rtl/nand_cycle_decoder_chk.sv
module nand_cycle_decoder_chk (
  input logic clk,
  input logic rst,
  input logic ce_n_i,
  input logic cle_i,
  input logic ale_i,
  input logic cmd_valid_o,
  input logic data_valid_o,
  input logic addr_done_o,
  input logic addr_err_o
);
  assert_cmd_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |=> !cmd_valid_o);

  assert_one_kind_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_valid_o, data_valid_o}));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    addr_done_o |=> !addr_done_o);

  assert_err_qualified_R6: assert property (@(posedge clk) disable iff (rst)
    !addr_done_o |-> !addr_err_o);

  // Pin levels reach the output strobes three clock samples later.
  assert_ce_gate_R7: assert property (@(posedge clk) disable iff (rst)
    $past(ce_n_i, 3) |-> !(cmd_valid_o || data_valid_o));

  assert_both_latch_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(cle_i, 3) && $past(ale_i, 3)) |-> !(cmd_valid_o || data_valid_o));

  assert_reset_quiet_R10: assert property (@(posedge clk)
    $past(rst) |-> !(cmd_valid_o || data_valid_o || addr_done_o || addr_err_o));
endmodule

bind nand_cycle_decoder nand_cycle_decoder_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .ce_n_i      (ce_n_i),
  .cle_i       (cle_i),
  .ale_i       (ale_i),
  .cmd_valid_o (cmd_valid_o),
  .data_valid_o(data_valid_o),
  .addr_done_o (addr_done_o),
  .addr_err_o  (addr_err_o)
);

// File: tb/nand_cycle_decoder_tb.sv
`timescale 1ns/1ps
module nand_cycle_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n_i = 1'b1, cle_i = 1'b0, ale_i = 1'b0, we_n_i = 1'b1;
  logic [7:0]  io_i = 8'h00;
  logic        cmd_valid_o, data_valid_o, addr_done_o, addr_err_o;
  logic [7:0]  cmd_code_o, data_o;
  logic [15:0] col_addr_o;
  logic [23:0] row_addr_o;
  logic [6:0]  page_o;
  logic [11:0] block_o;
  logic [0:0]  lun_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  // Captured results of the most recent bus cycle.
  logic        s_cmd, s_data, s_cmd2, s_done, s_err;
  logic [7:0]  s_code, s_byte;
  logic [15:0] s_col;
  logic [23:0] s_row;
  logic [6:0]  s_page;
  logic [11:0] s_block;
  logic        s_lun;

  always #4 clk = ~clk;  // 125 MHz

  nand_cycle_decoder u_dut (
    .clk(clk), .rst(rst), .ce_n_i(ce_n_i), .cle_i(cle_i), .ale_i(ale_i),
    .we_n_i(we_n_i), .io_i(io_i), .cmd_valid_o(cmd_valid_o),
    .cmd_code_o(cmd_code_o), .data_valid_o(data_valid_o), .data_o(data_o),
    .addr_done_o(addr_done_o), .addr_err_o(addr_err_o),
    .col_addr_o(col_addr_o), .row_addr_o(row_addr_o), .page_o(page_o),
    .block_o(block_o), .lun_o(lun_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // One bus cycle: strobe low for three clocks, rise on a falling clock edge,
  // sample strobes after the third rising edge, address results after the fourth.
  task automatic bus_cycle(input logic ce_n, input logic cle, input logic ale, input logic [7:0] b);
    @(negedge clk);
    ce_n_i = ce_n; cle_i = cle; ale_i = ale; io_i = b; we_n_i = 1'b0;
    repeat (3) @(negedge clk);
    we_n_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    s_cmd = cmd_valid_o; s_data = data_valid_o; s_code = cmd_code_o; s_byte = data_o;
    @(posedge clk);
    #1;
    s_cmd2 = cmd_valid_o; s_done = addr_done_o; s_err = addr_err_o;
    s_col = col_addr_o; s_row = row_addr_o;
    s_page = page_o; s_block = block_o; s_lun = lun_o[0];
    @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    bus_cycle(1'b0, 1'b1, 1'b0, op);
  endtask

  task automatic addr(input logic [7:0] b);
    bus_cycle(1'b0, 1'b0, 1'b1, b);
  endtask

  task automatic check_row_fields(input string tag, input logic [23:0] row);
    chk({tag, " R5 page"},  {25'd0, s_page},  {8'd0, row} & 32'h7f);
    chk({tag, " R5 block"}, {20'd0, s_block}, ({8'd0, row} >> 7) & 32'hfff);
    chk({tag, " R5 lun"},   {31'd0, s_lun},   ({8'd0, row} >> 19) & 32'h1);
  endtask

  task automatic t_reset;
    #1;
    chk("R10 cmd_valid after reset",  {31'd0, cmd_valid_o},  0);
    chk("R10 data_valid after reset", {31'd0, data_valid_o}, 0);
    chk("R10 addr_done after reset",  {31'd0, addr_done_o},  0);
    chk("R10 addr_err after reset",   {31'd0, addr_err_o},   0);
  endtask

  task automatic t_command;
    cmd(8'h80);
    chk("R1 cmd strobe", {31'd0, s_cmd}, 1);
    chk("R1 opcode", {24'd0, s_code}, 32'h80);
    chk("R1 single clock", {31'd0, s_cmd2}, 0);
    chk("R2 no data on command", {31'd0, s_data}, 0);
    cmd(8'h3C);
    chk("R1 second opcode", {24'd0, s_code}, 32'h3C);
  endtask

  task automatic t_data;
    bus_cycle(1'b0, 1'b0, 1'b0, 8'hA5);
    chk("R2 data strobe", {31'd0, s_data}, 1);
    chk("R2 data byte", {24'd0, s_byte}, 32'hA5);
    chk("R2 no cmd on data", {31'd0, s_cmd}, 0);
  endtask

  task automatic t_full_addr;
    cmd(8'h00);
    addr(8'h23); chk("R3 no done byte1", {31'd0, s_done}, 0);
    addr(8'h01); chk("R3 no done byte2", {31'd0, s_done}, 0);
    addr(8'h45); chk("R3 no done byte3", {31'd0, s_done}, 0);
    addr(8'h67); chk("R3 no done byte4", {31'd0, s_done}, 0);
    addr(8'h08);
    chk("R3 done byte5", {31'd0, s_done}, 1);
    chk("R3 column", {16'd0, s_col}, 32'h0123);
    chk("R3 row", {8'd0, s_row}, 32'h086745);
    chk("R6 clean address", {31'd0, s_err}, 0);
    check_row_fields("full", 24'h086745);
    cmd(8'h00);
    addr(8'h00); addr(8'h00); addr(8'h80); addr(8'h00); addr(8'h08);
    check_row_fields("lun1", 24'h080080);
  endtask

  task automatic t_erase;
    cmd(8'h60);
    addr(8'h11); chk("R4 no done byte1", {31'd0, s_done}, 0);
    addr(8'h22); chk("R4 no done byte2", {31'd0, s_done}, 0);
    addr(8'h03);
    chk("R4 done byte3", {31'd0, s_done}, 1);
    chk("R4 column zero", {16'd0, s_col}, 0);
    chk("R4 row", {8'd0, s_row}, 32'h032211);
    check_row_fields("erase", 24'h032211);
  endtask

  task automatic t_errors;
    cmd(8'h00);
    addr(8'h00); addr(8'hF0); addr(8'h00); addr(8'h00); addr(8'h00);
    chk("R6 column high bits done", {31'd0, s_done}, 1);
    chk("R6 column high bits err", {31'd0, s_err}, 1);
    cmd(8'h60);
    addr(8'h00); addr(8'h00); addr(8'h10);
    chk("R6 row high bits done", {31'd0, s_done}, 1);
    chk("R6 row high bits err", {31'd0, s_err}, 1);
  endtask

  task automatic t_interrupt;
    cmd(8'h00);
    addr(8'h11); addr(8'h02);
    cmd(8'h00);
    addr(8'h34); addr(8'h02);
    addr(8'h9A); chk("R8 restart no early done", {31'd0, s_done}, 0);
    addr(8'hBC); chk("R8 restart no done byte4", {31'd0, s_done}, 0);
    addr(8'h01);
    chk("R8 done after fresh five", {31'd0, s_done}, 1);
    chk("R8 column from new bytes", {16'd0, s_col}, 32'h0234);
    chk("R8 row from new bytes", {8'd0, s_row}, 32'h01BC9A);
  endtask

  task automatic t_chip_disabled;
    cmd(8'h00);
    addr(8'h55); addr(8'h05);
    bus_cycle(1'b1, 1'b1, 1'b0, 8'hFF);
    chk("R7 no cmd when disabled", {31'd0, s_cmd}, 0);
    bus_cycle(1'b1, 1'b0, 1'b1, 8'h77);
    chk("R7 no done when disabled", {31'd0, s_done}, 0);
    bus_cycle(1'b1, 1'b0, 1'b0, 8'h66);
    chk("R7 no data when disabled", {31'd0, s_data}, 0);
    addr(8'h01); addr(8'h02);
    chk("R7 count not advanced", {31'd0, s_done}, 0);
    addr(8'h03);
    chk("R7 done on real third row byte", {31'd0, s_done}, 1);
    chk("R7 column kept", {16'd0, s_col}, 32'h0555);
    chk("R7 row", {8'd0, s_row}, 32'h030201);
  endtask

  task automatic t_both_high;
    cmd(8'h00);
    addr(8'h66); addr(8'h06);
    bus_cycle(1'b0, 1'b1, 1'b1, 8'h99);
    chk("R9 no cmd", {31'd0, s_cmd}, 0);
    chk("R9 no data", {31'd0, s_data}, 0);
    chk("R9 no done", {31'd0, s_done}, 0);
    addr(8'h0A); addr(8'h0B);
    chk("R9 count not advanced", {31'd0, s_done}, 0);
    addr(8'h0C);
    chk("R9 done", {31'd0, s_done}, 1);
    chk("R9 row", {8'd0, s_row}, 32'h0C0B0A);
    chk("R9 column", {16'd0, s_col}, 32'h0666);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_command();
    t_data();
    t_full_addr();
    t_erase();
    t_errors();
    t_interrupt();
    t_chip_disabled();
    t_both_high();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule